// File: doc/BRIEF.md
# Serial Controller Host Register Front End

This block is the host-side register interface of a single-channel serial communications controller. The host sees two byte-wide ports, a control port and a data port, chosen by one address bit. Sixteen channel registers sit behind the control port. They are reached indirectly: one control write loads a register pointer, and the next control write stores into the register it names. A control read returns either the pointed register or the composite status byte. Several register writes also act as commands. They can clear pending flags, enable the transmitter or receiver, or reset the channel or the whole controller.

The block holds the channel's enable and pending flags and drives them to a separate interrupt prioritizer. Data-port writes model a transmitter that finishes at once. An optional internal loopback copies each sent byte into the receive data register. Two event inputs, driven by the rest of the channel, set the external-status pending flag and the baud pending flag. Read data is combinational: it is valid in the same cycle as the read strobe. All state changes take effect at the next rising clock edge. If write and read are asserted together, the write takes precedence.

Top module: `sio_host_regs`

## Requirements
- R1: In idle phase, a control write whose bits 7:4 are zero loads the pointer from bits 3:0 and arms the next control write as a load.
- R2: While a load is armed, a control write stores the byte into the pointed register and returns the interface to idle. The register then reads back that byte.
- R3: An idle control write of 0x10 clears the external-status and baud pending flags and leaves the pointer unchanged. In either phase, any other byte with nonzero bits 7:4 has no such effect. A pulse on ext_evt or baud_evt sets the matching flag, and a set wins over a clear in the same cycle.
- R4: A control read while a load is armed returns the pointed register and cancels the load. A control read in idle returns register 0 and forces the pointer to 0.
- R5: Register 0 reads as: bit 6 transmit underrun, bit 4 sync hunt, bit 2 stored transmit-empty, bit 0 stored receive-available. Bits 7, 5, 3 and 1 read 0.
- R6: Register 10 always reads 0.
- R7: A write to register 0 decodes bits 5:3. Value 2 clears sync hunt, value 5 clears transmit pending, and other values do nothing.
- R8: Register 1 sets the external interrupt enable (bit 0), the transmit interrupt enable (bit 1) and the receive interrupt mode (bits 4:3). Register 2 sets the vector. Register 3 sets the receiver enable (bit 0) and sync hunt (bit 4).
- R9: A write to register 5 sets the transmitter enable from bit 3. When bit 3 is 1, it also sets the stored transmit-empty bit (register 0 bit 2).
- R10: A write to register 9 sets the master interrupt enable from bit 3. Bits 7:6 = 1 reset the channel: all registers and channel flags clear, underrun becomes 1, and the master enable and vector are kept. Bits 7:6 = 3 also set sync hunt to 1 and clear the master enable and vector. Bits 7:6 = 2 do nothing.
- R11: A data-port write with the transmitter disabled changes nothing. When the transmitter is enabled, the write latches tx_byte and sets register 1 bit 0, register 0 bit 2, underrun and transmit pending.
- R12: If register 14 bit 4 is set when an accepted data write occurs, the byte also goes to the receive data register and sets register 0 bit 0. A data-port read returns the receive data register.
- R13: After reset the pointer is 0 and the interface is idle. All registers and flags are 0, except underrun and sync hunt, which are 1 (status reads 0x50).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Port access select |
| addr | input | 1 | 0 = control port, 1 = data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while cs and rd_en are high |
| ext_evt | input | 1 | Sets external-status pending |
| baud_evt | input | 1 | Sets baud pending |
| irq_master_en | output | 1 | Master interrupt enable |
| irq_ext_en | output | 1 | External interrupt enable |
| irq_tx_en | output | 1 | Transmit interrupt enable |
| rx_irq_mode | output | 2 | Receive interrupt mode |
| irq_vector | output | 8 | Interrupt vector |
| ext_pending | output | 1 | External-status interrupt pending |
| baud_pending | output | 1 | Baud interrupt pending |
| tx_pending | output | 1 | Transmit interrupt pending |
| tx_enabled | output | 1 | Transmitter enable |
| rx_enabled | output | 1 | Receiver enable |
| tx_byte | output | 8 | Last accepted transmit byte |

## Verification
The bench writes and reads back every plain register. It targets register 10, which a design that stored it would echo. It then sends a stray high-nibble control byte after a read that should have cancelled an armed load; if the read did not cancel the load, that byte would land in a register. All eight register-0 command codes are swept against sync hunt and transmit pending, which catches a decoder keyed to the wrong bits. The channel-reset and controller-reset codes are compared on the master enable and vector: if the two were swapped or merged, the bench would see those values survive or vanish at the wrong time.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam int unsigned REG_CMD  = 0;
  localparam int unsigned REG_IE   = 1;
  localparam int unsigned REG_VEC  = 2;
  localparam int unsigned REG_RXC  = 3;
  localparam int unsigned REG_TXC  = 5;
  localparam int unsigned REG_MIC  = 9;
  localparam int unsigned REG_NUL  = 10;
  localparam int unsigned REG_MISC = 14;

  localparam logic [2:0] CMD_CLR_HUNT = 3'd2;
  localparam logic [2:0] CMD_ACK_TX   = 3'd5;
  localparam logic [7:0] CLR_EXT_CODE = 8'h10;

  typedef enum logic {PH_IDLE = 1'b0, PH_LOAD = 1'b1} phase_e;
  typedef enum logic [1:0] {RST_NONE = 2'd0, RST_CHAN = 2'd1,
                            RST_NOP = 2'd2, RST_ALL = 2'd3} rstcmd_e;

  typedef struct packed {
    logic              master_ie;
    logic              ext_ie;
    logic              tx_ie;
    logic [1:0]        rx_mode;
    logic              rx_en;
    logic              tx_en;
    logic              hunt;
    logic              underrun;
    logic              tx_pend;
    logic              ext_pend;
    logic              baud_pend;
    logic [BYTE_W-1:0] vector;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] rx_byte;
  } chan_flags_t;
endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sio_ptr_ctl.sv
module sio_ptr_ctl
  import sio_regs_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned PTR_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr,
  output logic              in_load,
  output logic              reg_we,
  output logic              clr_ext
);
  phase_e           ph_q, ph_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ph_d    = ph_q;
    ptr_d   = ptr_q;
    reg_we  = 1'b0;
    clr_ext = 1'b0;
    if (ctl_wr) begin
      if (ph_q == PH_LOAD) begin
        reg_we = 1'b1;
        ph_d   = PH_IDLE;
      end else if (wdata[BYTE_W-1:PTR_W] == '0) begin
        ptr_d = wdata[PTR_W-1:0];
        ph_d  = PH_LOAD;
      end else if (wdata == CLR_EXT_CODE) begin
        clr_ext = 1'b1;
      end
    end else if (ctl_rd) begin
      if (ph_q == PH_LOAD) ph_d  = PH_IDLE;
      else                 ptr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      ptr_q <= '0;
    end else begin
      ph_q  <= ph_d;
      ptr_q <= ptr_d;
    end
  end

  assign ptr     = ptr_q;
  assign in_load = (ph_q == PH_LOAD);
endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
  import sio_regs_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned PTR_W = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [PTR_W-1:0]                 waddr,
  input  logic [BYTE_W-1:0]                wdata,
  input  logic [BYTE_W-1:0]                set0,
  input  logic [BYTE_W-1:0]                set1,
  input  logic                             clr_all,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]  q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] d_g, q_g, setm_g;

    assign setm_g = (g == 0) ? set0 : ((g == 1) ? set1 : '0);

    always_comb begin
      if (clr_all)
        d_g = '0;
      else
        d_g = ((we && (waddr == PTR_W'(g))) ? wdata : q_g) | setm_g;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_g <= '0;
      else        q_g <= d_g;
    end

    assign q[g] = q_g;
  end
endmodule

// File: rtl/sio_chan_flags.sv
module sio_chan_flags
  import sio_regs_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned PTR_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              dat_wr,
  input  logic              loop_en,
  input  logic              clr_ext,
  input  logic              ext_evt,
  input  logic              baud_evt,
  output chan_flags_t       flags,
  output logic [BYTE_W-1:0] set0,
  output logic [BYTE_W-1:0] set1,
  output logic              clr_regs
);
  chan_flags_t f_q, f_d;
  logic        chan_rst, all_rst;

  always_comb begin
    f_d      = f_q;
    set0     = '0;
    set1     = '0;
    chan_rst = 1'b0;
    all_rst  = 1'b0;

    if (reg_we) begin
      if (ptr == PTR_W'(REG_CMD)) begin
        if (wdata[5:3] == CMD_CLR_HUNT) f_d.hunt    = 1'b0;
        if (wdata[5:3] == CMD_ACK_TX)   f_d.tx_pend = 1'b0;
      end
      if (ptr == PTR_W'(REG_IE)) begin
        f_d.ext_ie  = wdata[0];
        f_d.tx_ie   = wdata[1];
        f_d.rx_mode = wdata[4:3];
      end
      if (ptr == PTR_W'(REG_VEC)) f_d.vector = wdata;
      if (ptr == PTR_W'(REG_RXC)) begin
        f_d.rx_en = wdata[0];
        f_d.hunt  = wdata[4];
      end
      if (ptr == PTR_W'(REG_TXC)) begin
        f_d.tx_en = wdata[3];
        set0[2]   = wdata[3];
      end
      if (ptr == PTR_W'(REG_MIC)) begin
        f_d.master_ie = wdata[3];
        chan_rst      = (rstcmd_e'(wdata[7:6]) == RST_CHAN);
        all_rst       = (rstcmd_e'(wdata[7:6]) == RST_ALL);
      end
    end

    if (dat_wr && f_q.tx_en) begin
      f_d.tx_byte  = wdata;
      f_d.underrun = 1'b1;
      f_d.tx_pend  = 1'b1;
      set0[2]      = 1'b1;
      set1[0]      = 1'b1;
      if (loop_en) begin
        f_d.rx_byte = wdata;
        set0[0]     = 1'b1;
      end
    end

    if (clr_ext) begin
      f_d.ext_pend  = 1'b0;
      f_d.baud_pend = 1'b0;
    end
    if (ext_evt)  f_d.ext_pend  = 1'b1;
    if (baud_evt) f_d.baud_pend = 1'b1;

    if (chan_rst || all_rst) begin
      f_d.ext_ie    = 1'b0;
      f_d.tx_ie     = 1'b0;
      f_d.rx_mode   = '0;
      f_d.rx_en     = 1'b0;
      f_d.tx_en     = 1'b0;
      f_d.hunt      = all_rst;
      f_d.underrun  = 1'b1;
      f_d.tx_pend   = 1'b0;
      f_d.ext_pend  = 1'b0;
      f_d.baud_pend = 1'b0;
      f_d.tx_byte   = '0;
      f_d.rx_byte   = '0;
      set0          = '0;
      set1          = '0;
      if (all_rst) begin
        f_d.master_ie = 1'b0;
        f_d.vector    = '0;
      end
    end
    clr_regs = chan_rst || all_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q          <= '0;
      f_q.hunt     <= 1'b1;
      f_q.underrun <= 1'b1;
    end else begin
      f_q <= f_d;
    end
  end

  assign flags = f_q;
endmodule

// File: rtl/sio_host_regs.sv
module sio_host_regs
  import sio_regs_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              ext_evt,
  input  logic              baud_evt,
  output logic              irq_master_en,
  output logic              irq_ext_en,
  output logic              irq_tx_en,
  output logic [1:0]        rx_irq_mode,
  output logic [BYTE_W-1:0] irq_vector,
  output logic              ext_pending,
  output logic              baud_pending,
  output logic              tx_pending,
  output logic              tx_enabled,
  output logic              rx_enabled,
  output logic [BYTE_W-1:0] tx_byte
);
  localparam int unsigned PTR_W = $clog2(NUM_REGS);

  logic                            rst_n_int;
  logic                            ctl_wr, ctl_rd, dat_wr;
  logic [PTR_W-1:0]                ptr;
  logic                            in_load, reg_we, clr_ext, clr_regs;
  logic [BYTE_W-1:0]               set0, set1;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
  chan_flags_t                     flags;
  logic [PTR_W-1:0]                rd_idx;
  logic [BYTE_W-1:0]               status, ctl_val;

  sio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  assign ctl_wr = cs && wr_en && !addr;
  assign ctl_rd = cs && rd_en && !wr_en && !addr;
  assign dat_wr = cs && wr_en && addr;

  sio_ptr_ctl #(.NUM_REGS(NUM_REGS)) u_ptr (
    .clk(clk), .rst_n(rst_n_int), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .wdata(wdata), .ptr(ptr), .in_load(in_load), .reg_we(reg_we),
    .clr_ext(clr_ext)
  );

  sio_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .we(reg_we), .waddr(ptr), .wdata(wdata),
    .set0(set0), .set1(set1), .clr_all(clr_regs), .q(regs)
  );

  sio_chan_flags #(.NUM_REGS(NUM_REGS)) u_flags (
    .clk(clk), .rst_n(rst_n_int), .reg_we(reg_we), .ptr(ptr), .wdata(wdata),
    .dat_wr(dat_wr), .loop_en(regs[REG_MISC][4]), .clr_ext(clr_ext),
    .ext_evt(ext_evt), .baud_evt(baud_evt), .flags(flags), .set0(set0),
    .set1(set1), .clr_regs(clr_regs)
  );

  // composite status byte and control-port read selection
  assign status = {1'b0, flags.underrun, 1'b0, flags.hunt,
                   1'b0, regs[REG_CMD][2], 1'b0, regs[REG_CMD][0]};
  assign rd_idx = in_load ? ptr : '0;

  always_comb begin
    if (rd_idx == PTR_W'(REG_CMD))      ctl_val = status;
    else if (rd_idx == PTR_W'(REG_NUL)) ctl_val = '0;
    else                                ctl_val = regs[rd_idx];
  end

  assign rdata = (cs && rd_en) ? (addr ? flags.rx_byte : ctl_val) : '0;

  assign irq_master_en = flags.master_ie;
  assign irq_ext_en    = flags.ext_ie;
  assign irq_tx_en     = flags.tx_ie;
  assign rx_irq_mode   = flags.rx_mode;
  assign irq_vector    = flags.vector;
  assign ext_pending   = flags.ext_pend;
  assign baud_pending  = flags.baud_pend;
  assign tx_pending    = flags.tx_pend;
  assign tx_enabled    = flags.tx_en;
  assign rx_enabled    = flags.rx_en;
  assign tx_byte       = flags.tx_byte;
endmodule

// File: rtl/sio_host_regs_chk.sv
module sio_host_regs_chk #(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned PTR_W = $clog2(NUM_REGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic             ext_evt,
  input logic             baud_evt,
  input logic             irq_master_en,
  input logic [7:0]       irq_vector,
  input logic             ext_pending,
  input logic             baud_pending,
  input logic             tx_pending,
  input logic             tx_enabled,
  input logic [7:0]       tx_byte,
  input logic             in_load,
  input logic [PTR_W-1:0] ptr
);
  p_clr_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && !addr && !in_load && wdata == 8'h10 && !ext_evt && !baud_evt)
    |=> (!ext_pending && !baud_pending && ptr == $past(ptr)));

  p_read_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd_en && !wr_en && !addr) |=> !in_load);

  p_idle_read_ptr0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd_en && !wr_en && !addr && !in_load) |=> (ptr == '0));

  p_status_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd_en && !addr && !in_load)
    |-> (rdata[7] == 1'b0 && rdata[5] == 1'b0 && rdata[3] == 1'b0 && rdata[1] == 1'b0));

  p_reg10_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd_en && !addr && in_load && ptr == PTR_W'(10)) |-> (rdata == 8'h00));

  p_full_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && !addr && in_load && ptr == PTR_W'(9) && wdata[7:6] == 2'b11)
    |=> (!irq_master_en && irq_vector == 8'h00));

  p_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && addr && !tx_enabled) |=> $stable(tx_byte));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && addr && tx_enabled) |=> (tx_pending && tx_byte == $past(wdata)));
endmodule

bind sio_host_regs sio_host_regs_chk #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/sio_host_regs_test.sv
`timescale 1ns/1ps
module sio_host_regs_test;
  logic       clk = 1'b0;
  logic       rst_n, cs, addr, wr_en, rd_en, ext_evt, baud_evt;
  logic [7:0] wdata, rdata, irq_vector, tx_byte;
  logic       irq_master_en, irq_ext_en, irq_tx_en, ext_pending, baud_pending;
  logic       tx_pending, tx_enabled, rx_enabled;
  logic [1:0] rx_irq_mode;
  int checks = 0;
  int fails  = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  sio_host_regs uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr_en = 0; wdata = 0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd_en = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd_en = 0;
  endtask

  task automatic wreg(input logic [3:0] n, input logic [7:0] d);
    bus_wr(0, {4'h0, n}); bus_wr(0, d);
  endtask

  task automatic rreg(input logic [3:0] n, output logic [7:0] d);
    bus_wr(0, {4'h0, n}); bus_rd(0, d);
  endtask

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 37) ^ 8'hA5);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cs = 0; addr = 0; wr_en = 0; rd_en = 0; wdata = 0;
    ext_evt = 0; baud_evt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);

    // R13 reset state
    bus_rd(0, v); chk("R13 status", v, 8'h50);
    chk("R13 master", irq_master_en, 0);
    chk("R13 tx_pending", tx_pending, 0);
    chk("R13 vector", irq_vector, 0);
    chk("R13 tx_byte", tx_byte, 0);
    rreg(7, v); chk("R13 reg7", v, 0);

    // R1 R2 R6 register sweep (skip command/reset registers 0, 5, 9)
    for (int n = 1; n < 16; n++)
      if (n != 5 && n != 9) wreg(4'(n), pat(n));
    for (int n = 1; n < 16; n++)
      if (n != 5 && n != 9) begin
        rreg(4'(n), v);
        if (n == 10) chk("R6 reg10 reads zero", v, 0);
        else         chk("R2 readback", v, pat(n));
      end
    wreg(1, 0); wreg(3, 0); wreg(14, 0);

    // R4 read cancels armed load; idle read returns status
    bus_wr(0, 8'h07); bus_rd(0, v); chk("R4 armed read", v, pat(7));
    bus_wr(0, 8'h55); rreg(7, v); chk("R4 disarmed", v, pat(7));
    bus_rd(0, v); chk("R4 idle read status", v, 8'h40);

    // R7 command field sweep, R5 status composition
    for (int c = 0; c < 8; c++) begin
      wreg(3, 8'h10); wreg(5, 8'h08);
      bus_wr(1, 8'(8'hE0 + c));
      chk("R11 tx_byte", tx_byte, 8'(8'hE0 + c));
      chk("R11 tx_pending set", tx_pending, 1);
      wreg(0, 8'(c << 3));
      bus_rd(0, v);
      chk("R7 R5 hunt in status", v, (c == 2) ? 8'h40 : 8'h50);
      chk("R7 tx_pending", tx_pending, (c == 5) ? 0 : 1);
      wreg(0, 8'h28);
    end

    // R9 transmitter enable, R11 ignored write
    wreg(5, 8'h00); chk("R9 tx disabled", tx_enabled, 0);
    bus_wr(1, 8'h3C);
    chk("R11 ignored tx_byte", tx_byte, 8'hE7);
    chk("R11 ignored pending", tx_pending, 0);
    wreg(0, 8'h00); wreg(5, 8'h08);
    chk("R9 tx enabled", tx_enabled, 1);
    bus_rd(0, v); chk("R9 status txe", v, 8'h54);

    // R8 enables, vector, receiver
    wreg(1, 8'h1B);
    chk("R8 ext_en", irq_ext_en, 1); chk("R8 tx_en", irq_tx_en, 1);
    chk("R8 rx mode", rx_irq_mode, 3);
    wreg(1, 8'h08);
    chk("R8 ext_en off", irq_ext_en, 0); chk("R8 rx mode 1", rx_irq_mode, 1);
    wreg(3, 8'h01); chk("R8 rx_enabled", rx_enabled, 1);
    bus_rd(0, v); chk("R8 hunt cleared", v, 8'h44);
    wreg(2, 8'hA5); chk("R8 vector", irq_vector, 8'hA5);

    // R11 accepted write sets all-sent
    bus_wr(1, 8'hC3);
    chk("R11 tx_byte", tx_byte, 8'hC3); chk("R11 pending", tx_pending, 1);
    rreg(1, v); chk("R11 all-sent", v, 8'h09);

    // R12 loopback
    wreg(14, 8'h10); bus_wr(1, 8'h96);
    bus_rd(1, v); chk("R12 loop data", v, 8'h96);
    bus_rd(0, v); chk("R12 rx avail", v, 8'h45);
    wreg(14, 8'h00); bus_wr(1, 8'h69);
    bus_rd(1, v); chk("R12 no loop", v, 8'h96);
    chk("R12 tx_byte", tx_byte, 8'h69);

    // R3 pending clear command
    @(negedge clk) begin ext_evt = 1; baud_evt = 1; end
    @(negedge clk) begin ext_evt = 0; baud_evt = 0; end
    chk("R3 ext set", ext_pending, 1); chk("R3 baud set", baud_pending, 1);
    bus_wr(0, 8'h20); chk("R3 other code", ext_pending, 1);
    wreg(7, 8'h10); chk("R3 load phase no clear", baud_pending, 1);
    rreg(7, v); chk("R3 stored 0x10", v, 8'h10);
    bus_wr(0, 8'h10);
    chk("R3 ext cleared", ext_pending, 0); chk("R3 baud cleared", baud_pending, 0);

    // R10 master enable and resets
    wreg(9, 8'h08); chk("R10 master", irq_master_en, 1);
    wreg(9, 8'h88); chk("R10 code2 no reset", tx_enabled, 1);
    wreg(9, 8'h48);
    chk("R10 chan keeps master", irq_master_en, 1);
    chk("R10 chan keeps vector", irq_vector, 8'hA5);
    chk("R10 chan tx off", tx_enabled, 0);
    chk("R10 chan pending", tx_pending, 0);
    rreg(7, v); chk("R10 chan regs cleared", v, 0);
    bus_rd(0, v); chk("R10 chan status", v, 8'h40);
    wreg(2, 8'h3C); wreg(9, 8'hC8);
    chk("R10 full master", irq_master_en, 0);
    chk("R10 full vector", irq_vector, 0);
    bus_rd(0, v); chk("R10 full status", v, 8'h50);
    rreg(2, v); chk("R10 full reg2", v, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule